// File: doc/BRIEF.md
# Three-Phase Hall Commutation Decoder

This block turns the three Hall-effect position bits of a three-phase brushless motor into six registered phase-driver enables. There is one high-side enable and one low-side enable for each of phases A, B and C. A two-bit spacing select tells the decoder how the sensors are placed around the rotor: 60, 120, 240 or 300 electrical degrees. A direction input reverses rotation. At every valid rotor position exactly one high-side and one low-side driver are enabled, and they are never on the same phase.

Around the decode sits a fixed priority. A brake request wins over everything else: it turns off every high-side driver and turns on every low-side driver, which shorts the windings together. Below brake, an enable input and an overcurrent-fault flag each force all drivers off. A low-side chop gate, driven by an external PWM source, blanks only the low-side enables. Speed control therefore never switches the high-side drivers, which change only at commutation steps.

The sense, spacing, direction and brake inputs pass through a configurable synchroniser. Its flops reset to the levels an unconnected input would read: sense bits high, spacing select zero, direction forward, brake off. Enable, chop and fault are treated as synchronous to the block clock, so a fault shuts the drivers off after a single edge. After reset the outputs stay off until the synchroniser has flushed and a valid sense code has arrived.

Top module: `bldc_hall_commutator`

## Requirements
- R1: In forward direction (`dir_fwd`=1), `spacing_sel` (0=60°, 1=120°, 2=240°, 3=300°) picks the table that maps the sense code {hall[2],hall[1],hall[0]} to one of six steps. The step order is A-hi/B-lo, C-hi/B-lo, C-hi/A-lo, B-hi/A-lo, B-hi/C-lo, A-hi/C-lo. The sense codes for these steps, in that order, are: 60° uses 000,100,110,111,011,001; 120° uses 001,101,100,110,010,011; 240° uses 010,110,100,101,001,011; 300° uses 011,111,110,100,000,001. Output bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R2: With `dir_fwd`=0, every step swaps its high-side and low-side phase (A-hi/B-lo becomes B-hi/A-lo).
- R3: Sense codes missing from the selected table turn all six outputs off: 010 and 101 at 60° and 300°, 000 and 111 at 120° and 240°.
- R4: Once armed, brake drives `hs_en`=000 and `ls_en`=111. This holds whatever the values of enable, fault, chop and sense-code validity.
- R5: With brake inactive, `enable`=0 or `fault`=1 turns all six outputs off. Clearing the condition restores the table output.
- R6: `chop`=0 forces `ls_en` to 000 and leaves `hs_en` unchanged. With `chop`=1 the low-side table value appears.
- R7: Reset clears all outputs. The outputs stay off, even under brake, until the synchroniser has flushed and a valid sense code has been seen. After that the block stays armed.
- R8: A change on hall, spacing, direction or brake reaches the outputs on the (SYNC_STAGES+1)-th rising edge after it is applied. A change on enable, chop or fault reaches them on the first edge.
- R9: No phase ever has its high-side and low-side enables on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall | input | 3 | Hall sense code, bit 2 = sensor 1, bit 0 = sensor 3 |
| spacing_sel | input | 2 | Sensor spacing: 0=60°, 1=120°, 2=240°, 3=300° |
| dir_fwd | input | 1 | 1 = forward, 0 = reverse |
| brake | input | 1 | Brake request, all low-side drivers on |
| enable | input | 1 | 0 turns every driver off |
| chop | input | 1 | Low-side PWM gate, 0 blanks the low side |
| fault | input | 1 | Overcurrent flag, 1 turns every driver off |
| hs_en | output | 3 | High-side enables, bit 0 = phase A |
| ls_en | output | 3 | Low-side enables, bit 0 = phase A |

## Verification
The bench uses the default of two synchroniser stages. This lets it check edge by edge that a sense change is still invisible after the first and second edges and appears on the third, while a fault or enable change takes effect after one edge. A full sweep over the four spacings, both directions and all eight sense codes covers every table entry and every blanked code. Directed cases cover arming from an invalid code under brake, brake overriding fault, enable, chop and invalid codes, and chop leaving the high side alone.

// File: rtl/bldc_comm_pkg.sv
// Shared types for the Hall commutation decoder.
// Assumes a three-phase motor with six commutation steps per electrical turn.
package bldc_comm_pkg;

    localparam int PHASES = 3;
    localparam int STEPS  = 6;
    localparam int SEL_W  = 2;
    localparam int HALL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SPACE_60  = 2'd0,
        SPACE_120 = 2'd1,
        SPACE_240 = 2'd2,
        SPACE_300 = 2'd3
    } spacing_e;

    typedef logic [PHASES-1:0] phase_vec_t;

    typedef struct packed {
        phase_vec_t hi;
        phase_vec_t lo;
    } drive_t;

    localparam drive_t DRIVE_OFF = '0;

    // One-hot phase vector for a phase index (0=A, 1=B, 2=C).
    function automatic phase_vec_t phase_bit(input logic [1:0] idx);
        return phase_vec_t'(1) << idx;
    endfunction

endpackage

// File: rtl/bldc_sync_bus.sv
// Multi-flop synchroniser for a bundle of slow asynchronous inputs.
// Assumes each bit changes slowly relative to clk. Bits are synchronised
// separately, with no coherence guarantee between them. With STAGES == 0
// the bus passes straight through. The primed output rises once the
// chain has been refilled with post-reset samples.
module bldc_sync_bus #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             primed
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q      = d;
            assign primed = 1'b1;
        end else begin : g_chain
            logic [WIDTH-1:0] chain [STAGES];
            logic [STAGES-1:0] fill;

            // Shift each input bit through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
                end else begin
                    chain[0] <= d;
                    for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
                end
            end

            // Track how many stages hold samples taken after reset.
            always_ff @(posedge clk) begin
                if (!rst_n) fill <= '0;
                else        fill <= {fill[STAGES-2:0], 1'b1};
            end

            assign q      = chain[STAGES-1];
            assign primed = fill[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/bldc_hall_decode.sv
// Combinational Hall decoder: sense code plus spacing gives a step index,
// and the step plus direction gives one high-side and one low-side phase.
// Assumes the sense code is already synchronised.
module bldc_hall_decode
    import bldc_comm_pkg::*;
(
    input  logic [HALL_W-1:0] hall,
    input  spacing_e          spacing,
    input  logic              fwd,
    output drive_t            drive,
    output logic              valid
);

    logic [2:0] step;
    logic [1:0] src_ph;
    logic [1:0] snk_ph;

    // Map the sense code to a step index for the chosen sensor spacing.
    always_comb begin
        step  = 3'd0;
        valid = 1'b1;
        unique case (spacing)
            SPACE_60: begin
                case (hall)
                    3'b000: step = 3'd0;
                    3'b100: step = 3'd1;
                    3'b110: step = 3'd2;
                    3'b111: step = 3'd3;
                    3'b011: step = 3'd4;
                    3'b001: step = 3'd5;
                    default: valid = 1'b0;
                endcase
            end
            SPACE_120: begin
                case (hall)
                    3'b001: step = 3'd0;
                    3'b101: step = 3'd1;
                    3'b100: step = 3'd2;
                    3'b110: step = 3'd3;
                    3'b010: step = 3'd4;
                    3'b011: step = 3'd5;
                    default: valid = 1'b0;
                endcase
            end
            SPACE_240: begin
                case (hall)
                    3'b010: step = 3'd0;
                    3'b110: step = 3'd1;
                    3'b100: step = 3'd2;
                    3'b101: step = 3'd3;
                    3'b001: step = 3'd4;
                    3'b011: step = 3'd5;
                    default: valid = 1'b0;
                endcase
            end
            default: begin
                case (hall)
                    3'b011: step = 3'd0;
                    3'b111: step = 3'd1;
                    3'b110: step = 3'd2;
                    3'b100: step = 3'd3;
                    3'b000: step = 3'd4;
                    3'b001: step = 3'd5;
                    default: valid = 1'b0;
                endcase
            end
        endcase
    end

    // Forward-direction source (high) and sink (low) phase for each step.
    always_comb begin
        case (step)
            3'd0:    begin src_ph = 2'd0; snk_ph = 2'd1; end
            3'd1:    begin src_ph = 2'd2; snk_ph = 2'd1; end
            3'd2:    begin src_ph = 2'd2; snk_ph = 2'd0; end
            3'd3:    begin src_ph = 2'd1; snk_ph = 2'd0; end
            3'd4:    begin src_ph = 2'd1; snk_ph = 2'd2; end
            default: begin src_ph = 2'd0; snk_ph = 2'd2; end
        endcase
    end

    // Reverse direction swaps source and sink within the step.
    always_comb begin
        drive = DRIVE_OFF;
        if (valid) begin
            drive.hi = phase_bit(fwd ? src_ph : snk_ph);
            drive.lo = phase_bit(fwd ? snk_ph : src_ph);
        end
    end

endmodule

// File: rtl/bldc_drive_arbiter.sv
// Output priority and registering stage. Priority order: not yet armed
// (all off), brake (low side on), enable/fault (all off), invalid code
// (all off), table with the low side gated by chop. Assumes enable, chop
// and fault are synchronous to clk.
module bldc_drive_arbiter
    import bldc_comm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       primed,
    input  drive_t     dec,
    input  logic       dec_valid,
    input  logic       brake,
    input  logic       enable,
    input  logic       fault,
    input  logic       chop,
    output phase_vec_t hs_en,
    output phase_vec_t ls_en,
    output logic       armed
);

    logic   armed_q;
    logic   arm_now;
    drive_t next_drv;
    drive_t drv_q;

    assign arm_now = primed & dec_valid;
    assign armed   = armed_q | arm_now;

    // Remember that a valid synchronised sense code has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (arm_now) armed_q <= 1'b1;
    end

    // Select the next driver pattern by priority.
    always_comb begin
        next_drv = DRIVE_OFF;
        if (armed) begin
            if (brake) begin
                next_drv.lo = '1;
            end else if (enable && !fault && dec_valid) begin
                next_drv.hi = dec.hi;
                next_drv.lo = chop ? dec.lo : '0;
            end
        end
    end

    // Register the enables so no decode glitch reaches the drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= DRIVE_OFF;
        else        drv_q <= next_drv;
    end

    assign hs_en = drv_q.hi;
    assign ls_en = drv_q.lo;

endmodule

// File: rtl/bldc_hall_commutator.sv
// Top level of the three-phase Hall commutation decoder. It synchronises
// the slow control inputs, decodes the rotor position and arbitrates the
// registered driver enables. Assumes active-high enables at the drivers.
module bldc_hall_commutator #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall,
    input  logic [1:0] spacing_sel,
    input  logic       dir_fwd,
    input  logic       brake,
    input  logic       enable,
    input  logic       chop,
    input  logic       fault,
    output logic [2:0] hs_en,
    output logic [2:0] ls_en
);
    import bldc_comm_pkg::*;

    localparam int BUS_W = HALL_W + SEL_W + 2;
    // Open-input levels: sense high, spacing 60, forward, no brake.
    localparam logic [BUS_W-1:0] BUS_RST = {{HALL_W{1'b1}}, {SEL_W{1'b0}}, 1'b1, 1'b0};

    logic [BUS_W-1:0]  raw_bus;
    logic [BUS_W-1:0]  sync_bus;
    logic              primed;
    logic [HALL_W-1:0] hall_s;
    logic [SEL_W-1:0]  sel_s;
    logic              dir_s;
    logic              brk_s;
    drive_t            dec_drv;
    logic              dec_ok;
    logic              armed;

    assign raw_bus = {hall, spacing_sel, dir_fwd, brake};

    bldc_sync_bus #(
        .WIDTH   (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (raw_bus),
        .q      (sync_bus),
        .primed (primed)
    );

    assign {hall_s, sel_s, dir_s, brk_s} = sync_bus;

    bldc_hall_decode u_dec (
        .hall    (hall_s),
        .spacing (spacing_e'(sel_s)),
        .fwd     (dir_s),
        .drive   (dec_drv),
        .valid   (dec_ok)
    );

    bldc_drive_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .primed    (primed),
        .dec       (dec_drv),
        .dec_valid (dec_ok),
        .brake     (brk_s),
        .enable    (enable),
        .fault     (fault),
        .chop      (chop),
        .hs_en     (hs_en),
        .ls_en     (ls_en),
        .armed     (armed)
    );

endmodule

// File: rtl/bldc_comm_checker.sv
// Property checker for the commutation decoder, bound into the top module.
module bldc_comm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hs_en,
    input logic [2:0] ls_en,
    input logic       enable,
    input logic       fault,
    input logic       chop,
    input logic       brk_s,
    input logic       armed
);

    // R9
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en & ls_en) == 3'b000);

    // R1
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_en));

    // R7
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (hs_en == 3'b000 && ls_en == 3'b000));

    // R4
    brake_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(brk_s) && $past(armed)) |-> (hs_en == 3'b000 && ls_en == 3'b111));

    // R5
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault) && !$past(brk_s)) |-> (hs_en == 3'b000 && ls_en == 3'b000));

    // R5
    enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(enable) && !$past(brk_s)) |-> (hs_en == 3'b000 && ls_en == 3'b000));

    // R6
    chop_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(chop) && !$past(brk_s)) |-> ls_en == 3'b000);

    // R1
    single_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(brk_s) |-> $countones(ls_en) <= 1);

endmodule

bind bldc_hall_commutator bldc_comm_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_en  (hs_en),
    .ls_en  (ls_en),
    .enable (enable),
    .fault  (fault),
    .chop   (chop),
    .brk_s  (brk_s),
    .armed  (armed)
);

// File: tb/bldc_hall_commutator_tb.sv
module bldc_hall_commutator_tb;

    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] b_hall = 3'b111;
    logic [1:0] b_sel = 2'd0;
    logic       b_dir = 1'b1;
    logic       b_brake = 1'b0;
    logic       b_en = 1'b1;
    logic       b_chop = 1'b1;
    logic       b_fault = 1'b0;
    logic [2:0] hs_en;
    logic [2:0] ls_en;

    int total = 0;
    int fails = 0;
    bit done = 0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    // Sense codes per spacing, listed in step order.
    localparam logic [2:0] CODES [4][6] = '{
        '{3'b000, 3'b100, 3'b110, 3'b111, 3'b011, 3'b001},
        '{3'b001, 3'b101, 3'b100, 3'b110, 3'b010, 3'b011},
        '{3'b010, 3'b110, 3'b100, 3'b101, 3'b001, 3'b011},
        '{3'b011, 3'b111, 3'b110, 3'b100, 3'b000, 3'b001}};
    // Forward source / sink phase per step (0=A,1=B,2=C).
    localparam int SRC [6] = '{0, 2, 2, 1, 1, 0};
    localparam int SNK [6] = '{1, 1, 0, 0, 2, 2};

    always #4 clk = ~clk;

    bldc_hall_commutator #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .hall(b_hall), .spacing_sel(b_sel),
        .dir_fwd(b_dir), .brake(b_brake), .enable(b_en), .chop(b_chop),
        .fault(b_fault), .hs_en(hs_en), .ls_en(ls_en));

    // Expected {hs_en, ls_en} from the requirements for the held inputs.
    function automatic logic [5:0] model_out(input bit armed);
        int  idx = 0;
        bit  hit = 0;
        int  hp, lp;
        logic [2:0] hi, lo;
        if (!armed)  return 6'b000000;
        if (b_brake) return 6'b000111;
        if (!b_en || b_fault) return 6'b000000;
        for (int i = 0; i < 6; i++)
            if (!hit && CODES[b_sel][i] == b_hall) begin idx = i; hit = 1; end
        if (!hit) return 6'b000000;
        hp = b_dir ? SRC[idx] : SNK[idx];
        lp = b_dir ? SNK[idx] : SRC[idx];
        hi = 3'b001 << hp;
        lo = b_chop ? (3'b001 << lp) : 3'b000;
        return {hi, lo};
    endfunction

    task automatic set_in(input logic [2:0] h, input logic [1:0] s, input bit d,
                          input bit bk, input bit en, input bit ch, input bit ft);
        @(negedge clk);
        b_hall = h; b_sel = s; b_dir = d; b_brake = bk;
        b_en = en; b_chop = ch; b_fault = ft;
    endtask

    task automatic push_val(input int n, input logic [5:0] v, input string tag);
        repeat (n) @(posedge clk);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic push_model(input int n, input string tag);
        repeat (n) @(posedge clk);
        exp_q.push_back(model_out(1'b1));
        tag_q.push_back(tag);
    endtask

    // Monitor: pop one expectation per edge and compare away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if ({hs_en, ls_en} !== e) begin
                    fails++;
                    $display("FAIL %s: got hs=%b ls=%b expected hs=%b ls=%b",
                             t, hs_en, ls_en, e[5:3], e[2:0]);
                end
                total++;
                if ((hs_en & ls_en) !== 3'b000) begin
                    fails++;
                    $display("FAIL R9: got overlap %b expected 000", hs_en & ls_en);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [5:0] prev;
        // R7: reset state
        push_val(3, 6'b000000, "R7 reset");
        // R7: invalid code under brake right after reset must stay off
        @(negedge clk);
        b_hall = 3'b010; b_brake = 1'b1;
        rst_n = 1'b1;
        push_val(6, 6'b000000, "R7 unarmed brake");
        // R7/R1: first valid code arms the block (A-hi/B-lo)
        set_in(3'b000, 2'd0, 1, 0, 1, 1, 0);
        push_val(LAT + 1, 6'b001010, "R7 armed");

        // R8: sense change seen on edge LAT, not before
        prev = model_out(1'b1);
        set_in(3'b100, 2'd0, 1, 0, 1, 1, 0);
        push_val(1, prev, "R8 edge1");
        push_val(1, prev, "R8 edge2");
        push_val(1, 6'b100010, "R8 edge3");

        // R6: chop blanks only low side (C-hi/B-lo held)
        set_in(3'b100, 2'd0, 1, 0, 1, 0, 0);
        push_val(1, 6'b100000, "R6 chop low");
        set_in(3'b100, 2'd0, 1, 0, 1, 1, 0);
        push_val(1, 6'b100010, "R6 chop high");

        // R5/R8: fault and enable act after one edge
        set_in(3'b100, 2'd0, 1, 0, 1, 1, 1);
        push_val(1, 6'b000000, "R5 fault");
        set_in(3'b100, 2'd0, 1, 0, 1, 1, 0);
        push_val(1, 6'b100010, "R5 fault cleared");
        set_in(3'b100, 2'd0, 1, 0, 0, 1, 0);
        push_val(1, 6'b000000, "R5 enable low");

        // R4: brake beats enable low, fault, chop low
        set_in(3'b100, 2'd0, 1, 1, 0, 0, 1);
        push_val(LAT + 1, 6'b000111, "R4 brake over all");
        // R4: brake beats an invalid code
        set_in(3'b101, 2'd0, 1, 1, 1, 1, 0);
        push_val(LAT + 1, 6'b000111, "R4 brake invalid");
        set_in(3'b101, 2'd0, 1, 0, 1, 1, 0);
        push_val(LAT + 1, 6'b000000, "R3 invalid 60");

        // R1/R2/R3: full sweep of spacing, direction and sense code
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int h = 0; h < 8; h++) begin
                    string tg;
                    set_in(3'(h), 2'(s), d[0], 0, 1, 1, 0);
                    tg = (model_out(1'b1) == 6'b000000) ? "R3 sweep" :
                         (d == 1) ? "R1 sweep" : "R2 sweep";
                    push_model(LAT + 1, tg);
                end
            end
        end

        repeat (4) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule